// File: doc/BRIEF.md
# Reset-Source and Clock-Supervision Status Register

This block is a byte-wide system status and control register. Its main job is to record which kind of reset last hit the chip: the external reset pin, the watchdog, or the low-voltage detector. It also shows a supply-voltage warning level and a clock-security fault. It raises a separate interrupt request for each of these two conditions. The analog detectors, the oscillators and the CPU sit outside the block. The block only sees their event pulses and levels, together with a simple register access port.

The reset events arrive as one-cycle pulses. They are not resets of this block, so the flags keep their values across the very resets they log. Only the power-on reset input `rst` initialises the register. A first power-up is logged as a low-voltage reset.

Software finds the cause of the last reset by reading the two reset flags as a pair. It acknowledges a flag by writing zero to it. The clock-fault flag is cleared by reading the register, but only once the main oscillator is running again.

Top module: `rsc_status_reg`

## Requirements
- R1: After power-on reset the read data is 8'h02. The low-voltage flag (bit 1) is set and every other bit is clear. Both interrupt outputs are low.
- R2: A low-voltage event pulse sets bit 1 and clears bit 0 on the next clock edge. This holds even when a software write or a watchdog event happens in the same cycle. Bits {1,0} then read 2'b10 or 2'b11 as "low-voltage".
- R3: A watchdog event without a low-voltage event sets bit 0 and leaves bit 1 unchanged. With bit 1 clear, bits {1,0} = 2'b01 mean "watchdog".
- R4: An external-pin event changes neither reset flag. After both flags are cleared, bits {1,0} = 2'b00 mean "external pin".
- R5: A write with bit 0 or bit 1 at zero clears that flag. A written one is ignored. A hardware set in the same cycle wins over a software clear.
- R6: Bit 5 follows the voltage comparator input, which passes through a SYNC_STAGES-flop synchronizer. With the default of 2 stages, a change shows on the second clock edge. Writes to bit 5 are ignored.
- R7: When the voltage-interrupt enable (bit 6, read/write) is set, each change of bit 5 gives a one-cycle `irq_volt` pulse. The pulse appears in the same cycle as the change and covers both rising and falling edges. When bit 6 is clear, no pulse is produced.
- R8: Clock-fault bit 3 is set on the edge after `osc_fail` is seen while `pll_on` is high. A read while `osc_fail` is still high leaves bit 3 set. Recovery without a read also leaves it set. A read in a cycle with `osc_fail` low clears it, including the cycle in which recovery happens.
- R9: `irq_clk` is high exactly while the clock-interrupt enable (bit 2, read/write), bit 3 and `pll_on` are all high.
- R10: While `pll_on` is low, bit 3 is forced clear on the next edge and stays clear. `irq_clk` stays low whatever bit 2 holds.
- R11: Bits 7 and 4 always read zero. Writes to bits 3, 4, 5 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ev_lv | input | 1 | Low-voltage reset event pulse |
| ev_wd | input | 1 | Watchdog reset event pulse |
| ev_ext | input | 1 | External-pin reset event pulse |
| vdet_lvl | input | 1 | Asynchronous voltage-warning comparator level |
| osc_fail | input | 1 | Main oscillator failure level |
| pll_on | input | 1 | PLL enabled |
| cpu_cs | input | 1 | Register select |
| cpu_we | input | 1 | Write strobe (with cpu_cs) |
| cpu_rd | input | 1 | Read strobe (with cpu_cs) |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Current register contents |
| irq_volt | output | 1 | Voltage-warning change interrupt pulse |
| irq_clk | output | 1 | Clock-security interrupt request |

## Verification
A wrong internal state shows up on `cpu_rdata` on the clock edge after the event or access that caused it. Examples are a reset flag set or cleared by the wrong event, or a clock-fault bit that clears too early. The same state also drives `irq_clk` in that cycle. A fault in the voltage path shows two edges after the comparator moves. It appears as a wrong bit 5, and as a missing, extra or stretched `irq_volt` pulse. The bench therefore samples every output once per cycle around each stimulus, so a deviation is caught within one to three cycles.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    localparam int REG_W   = 8;
    localparam int B_WDF   = 0;
    localparam int B_LVF   = 1;
    localparam int B_CIE   = 2;
    localparam int B_CSD   = 3;
    localparam int B_RSV   = 4;
    localparam int B_VWF   = 5;
    localparam int B_VIE   = 6;
    localparam int B_TOP   = 7;

    typedef struct packed {
        logic lv;
        logic wd;
        logic ext;
    } rst_evt_t;

    typedef struct packed {
        logic lvf;
        logic wdf;
    } rst_flags_t;

    typedef struct packed {
        logic vie;
        logic vwf;
    } volt_state_t;

    typedef struct packed {
        logic cie;
        logic csd;
    } clk_state_t;

    localparam rst_flags_t FLAGS_POR = '{lvf: 1'b1, wdf: 1'b0};

    function automatic logic [REG_W-1:0] pack_status(
        input rst_flags_t  rf,
        input volt_state_t vs,
        input clk_state_t  cs
    );
        logic [REG_W-1:0] d;
        d        = '0;
        d[B_WDF] = rf.wdf;
        d[B_LVF] = rf.lvf;
        d[B_CIE] = cs.cie;
        d[B_CSD] = cs.csd;
        d[B_RSV] = 1'b0;
        d[B_VWF] = vs.vwf;
        d[B_VIE] = vs.vie;
        d[B_TOP] = 1'b0;
        return d;
    endfunction

endpackage

// File: rtl/rsc_reset_log.sv
module rsc_reset_log
    import rsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  rst_evt_t   evt,
    input  logic       wr,
    input  logic       wd_lvf,
    input  logic       wd_wdf,
    output rst_flags_t flags
);

    rst_flags_t q;
    logic       unused_ext;

    // External-pin events are logged by the absence of either flag.
    assign unused_ext = evt.ext;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= FLAGS_POR;
        end else if (evt.lv) begin
            q.lvf <= 1'b1;
            q.wdf <= 1'b0;
        end else begin
            if (wr && !wd_lvf)
                q.lvf <= 1'b0;
            if (evt.wd)
                q.wdf <= 1'b1;
            else if (wr && !wd_wdf)
                q.wdf <= 1'b0;
        end
    end

    assign flags = q;

endmodule

// File: rtl/rsc_volt_mon.sv
module rsc_volt_mon
    import rsc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        lvl_async,
    input  logic        wr,
    input  logic        wd_vie,
    output volt_state_t st,
    output logic        irq
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl_s;
    logic                   lvl_prev;
    logic                   vie_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= lvl_async;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], lvl_async};
            end
        end
    endgenerate

    assign lvl_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_prev <= 1'b0;
            vie_q    <= 1'b0;
        end else begin
            lvl_prev <= lvl_s;
            if (wr)
                vie_q <= wd_vie;
        end
    end

    assign st.vwf = lvl_s;
    assign st.vie = vie_q;
    assign irq    = vie_q & (lvl_s ^ lvl_prev);

endmodule

// File: rtl/rsc_clk_sec.sv
module rsc_clk_sec
    import rsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_fail,
    input  logic       pll_on,
    input  logic       wr,
    input  logic       rd,
    input  logic       wd_cie,
    output clk_state_t st,
    output logic       irq
);

    clk_state_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            if (wr)
                q.cie <= wd_cie;
            if (!pll_on)
                q.csd <= 1'b0;
            else if (osc_fail)
                q.csd <= 1'b1;
            else if (rd)
                q.csd <= 1'b0;
        end
    end

    assign st  = q;
    assign irq = pll_on & q.cie & q.csd;

endmodule

// File: rtl/rsc_status_reg.sv
module rsc_status_reg
    import rsc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_lv,
    input  logic             ev_wd,
    input  logic             ev_ext,
    input  logic             vdet_lvl,
    input  logic             osc_fail,
    input  logic             pll_on,
    input  logic             cpu_cs,
    input  logic             cpu_we,
    input  logic             cpu_rd,
    input  logic [REG_W-1:0] cpu_wdata,
    output logic [REG_W-1:0] cpu_rdata,
    output logic             irq_volt,
    output logic             irq_clk
);

    rst_evt_t    evt;
    rst_flags_t  rflags;
    volt_state_t vstate;
    clk_state_t  cstate;
    logic        acc_wr;
    logic        acc_rd;
    logic        unused_wbits;

    assign evt          = '{lv: ev_lv, wd: ev_wd, ext: ev_ext};
    assign acc_wr       = cpu_cs & cpu_we;
    assign acc_rd       = cpu_cs & cpu_rd;
    assign unused_wbits = ^{cpu_wdata[B_TOP], cpu_wdata[B_VWF],
                            cpu_wdata[B_RSV], cpu_wdata[B_CSD]};

    rsc_reset_log u_rlog (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .wr     (acc_wr),
        .wd_lvf (cpu_wdata[B_LVF]),
        .wd_wdf (cpu_wdata[B_WDF]),
        .flags  (rflags)
    );

    rsc_volt_mon #(.SYNC_STAGES(SYNC_STAGES)) u_volt (
        .clk       (clk),
        .rst       (rst),
        .lvl_async (vdet_lvl),
        .wr        (acc_wr),
        .wd_vie    (cpu_wdata[B_VIE]),
        .st        (vstate),
        .irq       (irq_volt)
    );

    rsc_clk_sec u_csec (
        .clk      (clk),
        .rst      (rst),
        .osc_fail (osc_fail),
        .pll_on   (pll_on),
        .wr       (acc_wr),
        .rd       (acc_rd),
        .wd_cie   (cpu_wdata[B_CIE]),
        .st       (cstate),
        .irq      (irq_clk)
    );

    assign cpu_rdata = pack_status(rflags, vstate, cstate);

endmodule

// File: rtl/rsc_status_chk.sv
module rsc_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       ev_lv,
    input logic       ev_wd,
    input logic       ev_ext,
    input logic       osc_fail,
    input logic       pll_on,
    input logic       cpu_cs,
    input logic       cpu_we,
    input logic [7:0] cpu_rdata,
    input logic       irq_volt,
    input logic       irq_clk
);

    assert_lv_sets_R2: assert property (@(posedge clk) disable iff (rst)
        ev_lv |=> (cpu_rdata[1] && !cpu_rdata[0]));

    assert_wd_sets_R3: assert property (@(posedge clk) disable iff (rst)
        (ev_wd && !ev_lv) |=> cpu_rdata[0]);

    assert_ext_keeps_R4: assert property (@(posedge clk) disable iff (rst)
        (ev_ext && !ev_lv && !ev_wd && !(cpu_cs && cpu_we))
        |=> $stable(cpu_rdata[1:0]));

    assert_no_sw_set_R5: assert property (@(posedge clk) disable iff (rst)
        (!ev_lv && !cpu_rdata[1]) |=> !cpu_rdata[1]);

    assert_volt_irq_en_R7: assert property (@(posedge clk) disable iff (rst)
        irq_volt |-> cpu_rdata[6]);

    assert_fault_sets_R8: assert property (@(posedge clk) disable iff (rst)
        (pll_on && osc_fail) |=> cpu_rdata[3]);

    assert_clk_irq_pll_R9: assert property (@(posedge clk) disable iff (rst)
        irq_clk |-> (pll_on && cpu_rdata[2]));

    assert_pll_off_R10: assert property (@(posedge clk) disable iff (rst)
        !pll_on |=> !cpu_rdata[3]);

    assert_reserved_R11: assert property (@(posedge clk) disable iff (rst)
        (cpu_rdata[7] == 1'b0) && (cpu_rdata[4] == 1'b0));

endmodule

bind rsc_status_reg rsc_status_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ev_lv     (ev_lv),
    .ev_wd     (ev_wd),
    .ev_ext    (ev_ext),
    .osc_fail  (osc_fail),
    .pll_on    (pll_on),
    .cpu_cs    (cpu_cs),
    .cpu_we    (cpu_we),
    .cpu_rdata (cpu_rdata),
    .irq_volt  (irq_volt),
    .irq_clk   (irq_clk)
);

// File: tb/tb_rsc_status_reg.sv
module tb_rsc_status_reg;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ev_lv = 0, ev_wd = 0, ev_ext = 0;
    logic       vdet_lvl = 0, osc_fail = 0, pll_on = 0;
    logic       cpu_cs = 0, cpu_we = 0, cpu_rd = 0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       irq_volt, irq_clk;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    rsc_status_reg dut (
        .clk(clk), .rst(rst), .ev_lv(ev_lv), .ev_wd(ev_wd), .ev_ext(ev_ext),
        .vdet_lvl(vdet_lvl), .osc_fail(osc_fail), .pll_on(pll_on),
        .cpu_cs(cpu_cs), .cpu_we(cpu_we), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .irq_volt(irq_volt), .irq_clk(irq_clk)
    );

    // {lv, wd, ext, we, wdata[7:0], expected {lvf,wdf}}
    localparam int NV = 13;
    localparam logic [13:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 2'b10},
        {1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 2'b11},
        {1'b0, 1'b0, 1'b0, 1'b1, 8'h03, 2'b11},
        {1'b0, 1'b0, 1'b0, 1'b1, 8'h02, 2'b10},
        {1'b0, 1'b0, 1'b0, 1'b1, 8'h01, 2'b00},
        {1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 2'b01},
        {1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 2'b01},
        {1'b0, 1'b0, 1'b0, 1'b1, 8'h03, 2'b01},
        {1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 2'b10},
        {1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 2'b01},
        {1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 2'b10},
        {1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 2'b00},
        {1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 2'b00}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        cpu_cs = 1; cpu_we = 1; cpu_wdata = d;
        step();
        cpu_cs = 0; cpu_we = 0; cpu_wdata = '0;
    endtask

    task automatic rd_access();
        cpu_cs = 1; cpu_rd = 1;
        step();
        cpu_cs = 0; cpu_rd = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #1;
        step(); step();
        rst = 0;
        // R1: power-on state
        chk("R1", cpu_rdata, 8'h02);
        chk("R1", {6'd0, irq_volt, irq_clk}, 8'h00);

        // R2 R3 R4 R5: reset-source table
        for (int i = 0; i < NV; i++) begin
            ev_lv = VEC[i][13]; ev_wd = VEC[i][12]; ev_ext = VEC[i][11];
            cpu_cs = VEC[i][10]; cpu_we = VEC[i][10]; cpu_wdata = VEC[i][9:2];
            step();
            ev_lv = 0; ev_wd = 0; ev_ext = 0; cpu_cs = 0; cpu_we = 0; cpu_wdata = '0;
            if (VEC[i][13])      chk("R2", {6'd0, cpu_rdata[1:0]}, {6'd0, VEC[i][1:0]});
            else if (VEC[i][12]) chk("R3", {6'd0, cpu_rdata[1:0]}, {6'd0, VEC[i][1:0]});
            else if (VEC[i][11]) chk("R4", {6'd0, cpu_rdata[1:0]}, {6'd0, VEC[i][1:0]});
            else                 chk("R5", {6'd0, cpu_rdata[1:0]}, {6'd0, VEC[i][1:0]});
        end

        // R6 R7: voltage warning with enable
        wr(8'h40);
        vdet_lvl = 1;
        step();
        chk("R6", {7'd0, cpu_rdata[5]}, 8'h00);
        chk("R7", {7'd0, irq_volt}, 8'h00);
        step();
        chk("R6", {7'd0, cpu_rdata[5]}, 8'h01);
        chk("R7", {7'd0, irq_volt}, 8'h01);
        step();
        chk("R7", {7'd0, irq_volt}, 8'h00);
        vdet_lvl = 0;
        step(); step();
        chk("R6", {7'd0, cpu_rdata[5]}, 8'h00);
        chk("R7", {7'd0, irq_volt}, 8'h01);
        step();
        chk("R7", {7'd0, irq_volt}, 8'h00);
        // R7: disabled -> no pulse
        wr(8'h00);
        vdet_lvl = 1;
        step();
        chk("R7", {7'd0, irq_volt}, 8'h00);
        step();
        chk("R7", {7'd0, irq_volt}, 8'h00);
        chk("R6", {7'd0, cpu_rdata[5]}, 8'h01);
        vdet_lvl = 0;
        repeat (3) step();
        // R6 R11: writes to read-only bits ignored
        wr(8'hA8);
        chk("R11", cpu_rdata, 8'h00);

        // R8 R9: clock security
        pll_on = 1;
        wr(8'h04);
        osc_fail = 1;
        step();
        chk("R8", {7'd0, cpu_rdata[3]}, 8'h01);
        chk("R9", {7'd0, irq_clk}, 8'h01);
        rd_access();
        chk("R8", {7'd0, cpu_rdata[3]}, 8'h01);
        osc_fail = 0;
        step();
        chk("R8", {7'd0, cpu_rdata[3]}, 8'h01);
        rd_access();
        chk("R8", {7'd0, cpu_rdata[3]}, 8'h00);
        chk("R9", {7'd0, irq_clk}, 8'h00);
        osc_fail = 1;
        step();
        osc_fail = 0;
        rd_access();
        chk("R8", {7'd0, cpu_rdata[3]}, 8'h00);
        wr(8'h00);
        osc_fail = 1;
        step();
        chk("R9", {6'd0, cpu_rdata[3], irq_clk}, 8'h02);

        // R10: PLL off
        wr(8'h04);
        chk("R9", {7'd0, irq_clk}, 8'h01);
        pll_on = 0;
        #1;
        chk("R10", {7'd0, irq_clk}, 8'h00);
        step();
        chk("R10", {6'd0, cpu_rdata[3], irq_clk}, 8'h00);
        step();
        chk("R10", {7'd0, cpu_rdata[3]}, 8'h00);
        chk("R10", {7'd0, cpu_rdata[2]}, 8'h01);
        osc_fail = 0;

        // R11: reserved bits
        wr(8'hFF);
        chk("R11", {6'd0, cpu_rdata[7], cpu_rdata[4]}, 8'h00);

        // R1: reset again restores power-on value
        rst = 1;
        step();
        rst = 0;
        chk("R1", cpu_rdata, 8'h02);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule